// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that sits on a two-wire bus and gives an external controller byte-wide read and write access to a small internal register file. SCL and SDA are oversampled by the system clock through a short synchronizer. START, STOP and repeated START are found as SDA edges while SCL is high. The block decodes a fixed 7-bit target address and a direction bit, and then runs the pointer and data phases of the transfer. SDA is never driven high. The block only asserts an open-drain pull-down enable, and the pad is expected to turn that into a low level on the wire.

A write transfer sends the address byte with direction 0, then one pointer byte, then any number of data bytes. Each data byte goes to the register that the pointer selects, and the pointer then steps to the next register. A read transfer first sets the pointer with a write phase, then issues a repeated START and an address byte with direction 1. The target then shifts out register contents until the controller leaves the ninth bit high.

A separate active-low quiet input forces the pull-down enable off at all times, so no acknowledge and no read data reach the wire. Reception carries on behind it. Each register write is also reported on a one-cycle write strobe with its index and data.

Top module: `i2c_tgt`

## Requirements
- R1: After reset, sdaOe and wrValid are 0, the register pointer is 0 and every register holds 0x00.
- R2: The first byte after a START is the 7-bit address in bits 7..1 plus a direction bit in bit 0 (0 = write, 1 = read). On address 0x60 the target pulls SDA low during the ninth SCL pulse.
- R3: An address other than 0x60 gets no acknowledge. The target then writes nothing and drives nothing until the next START or STOP.
- R4: In a write, the byte after the address is the register pointer; the low REG_IDX_W bits select one of 2^REG_IDX_W registers. Every later byte is stored in the selected register and acknowledged. A store is reported by a one-cycle wrValid pulse carrying wrAddr and wrData.
- R5: The pointer increments after each data byte that is written or read, wrapping from the last register to register 0.
- R6: After an address byte with direction 1, the target shifts out the selected register most significant bit first. It changes SDA only while SCL is low.
- R7: If the controller pulls SDA low in the ninth pulse of a read byte, the next register follows. If it leaves SDA high, the target releases SDA and stays silent until the next START or STOP.
- R8: While quietN is 0, sdaOe stays 0, so neither acknowledge nor read data appears on the bus. Received write bytes are still stored.
- R9: A STOP or a START at any bit position abandons the current byte without storing it. A START begins a new address byte and keeps the pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL level from the pad |
| sdaIn | input | 1 | SDA level from the pad |
| quietN | input | 1 | Active-low gate; when 0, SDA is never driven |
| sdaOe | output | 1 | Open-drain enable; 1 pulls SDA low |
| wrValid | output | 1 | One-cycle strobe for each register store |
| wrAddr | output | REG_IDX_W | Index of the stored register |
| wrData | output | 8 | Byte stored |

## Verification
The properties assume that each SCL high and low phase lasts much longer than the synchronizer delay of about three system clocks. They also assume that the controller moves SDA only while SCL is low, except when it signals START or STOP, and that it never signals START or STOP while the target holds SDA low. The bench's controller tasks hold each quarter bit for ten system clocks. They change data only in the SCL low phase and end every ninth pulse before any bus condition. Under quietN = 0 the bench sees the bus idle high, and it follows the transfer as a controller would that receives no acknowledge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_FALL,
    ST_ACK_RISE,
    ST_ACK_END,
    ST_TX,
    ST_TX_END,
    ST_TX_ACK,
    ST_TX_NEXT,
    ST_IGNORE
  } tgtStateT;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } rxPhaseT;

  // One-cycle commands from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic setPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
  } tgtStrobeT;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclChain;
  logic [LAST:0] sdaChain;
  logic          sclLvl;
  logic          sclDly;
  logic          sdaDly;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= sclIn;
          sdaChain <= sdaIn;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[LAST-1:0], sclIn};
          sdaChain <= {sdaChain[LAST-1:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclLvl = sclChain[LAST];
  assign sdaLvl = sdaChain[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclDly <= 1'b1;
      sdaDly <= 1'b1;
    end else begin
      sclDly <= sclLvl;
      sdaDly <= sdaLvl;
    end
  end

  assign sclRise  = sclLvl & ~sclDly;
  assign sclFall  = ~sclLvl & sclDly;
  assign startDet = sclLvl & sclDly & sdaDly & ~sdaLvl;
  assign stopDet  = sclLvl & sclDly & ~sdaDly & sdaLvl;

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h60
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      sdaLvl,
  input  logic [7:0] rxByte,
  input  logic      txMsb,
  output tgtStrobeT stb,
  output logic      driveLow
);

  tgtStateT   state,   stateN;
  rxPhaseT    phase,   phaseN;
  logic [2:0] bitCnt,  bitCntN;
  logic       ackFlag, ackFlagN;
  logic       isRead,  isReadN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= PH_ADDR;
      bitCnt  <= '0;
      ackFlag <= 1'b0;
      isRead  <= 1'b0;
    end else begin
      state   <= stateN;
      phase   <= phaseN;
      bitCnt  <= bitCntN;
      ackFlag <= ackFlagN;
      isRead  <= isReadN;
    end
  end

  always_comb begin
    stateN   = state;
    phaseN   = phase;
    bitCntN  = bitCnt;
    ackFlagN = ackFlag;
    isReadN  = isRead;
    stb      = '0;

    if (stopDet) begin
      stateN   = ST_IDLE;
      ackFlagN = 1'b0;
    end else if (startDet) begin
      stateN   = ST_RX;
      phaseN   = PH_ADDR;
      bitCntN  = '0;
      ackFlagN = 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            if (bitCnt == 3'd7) begin
              bitCntN = '0;
              stateN  = ST_ACK_FALL;
            end else begin
              bitCntN = bitCnt + 3'd1;
            end
          end
        end
        ST_ACK_FALL: begin
          if (sclFall) begin
            unique case (phase)
              PH_ADDR: begin
                if (rxByte[7:1] == TGT_ADDR) begin
                  ackFlagN = 1'b1;
                  isReadN  = rxByte[0];
                  stateN   = ST_ACK_RISE;
                end else begin
                  stateN = ST_IGNORE;
                end
              end
              PH_PTR: begin
                stb.setPtr = 1'b1;
                ackFlagN   = 1'b1;
                stateN     = ST_ACK_RISE;
              end
              default: begin
                stb.writeReg = 1'b1;
                ackFlagN     = 1'b1;
                stateN       = ST_ACK_RISE;
              end
            endcase
          end
        end
        ST_ACK_RISE: begin
          if (sclRise) stateN = ST_ACK_END;
        end
        ST_ACK_END: begin
          if (sclFall) begin
            ackFlagN = 1'b0;
            if (phase == PH_ADDR && isRead) begin
              stb.loadTx = 1'b1;
              bitCntN    = '0;
              stateN     = ST_TX;
            end else begin
              phaseN = (phase == PH_ADDR) ? PH_PTR : PH_DATA;
              stateN = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            if (bitCnt == 3'd7) begin
              bitCntN = '0;
              stateN  = ST_TX_END;
            end else begin
              bitCntN = bitCnt + 3'd1;
            end
          end
          if (sclFall) stb.shiftTx = 1'b1;
        end
        ST_TX_END: begin
          if (sclFall) stateN = ST_TX_ACK;
        end
        ST_TX_ACK: begin
          if (sclRise) stateN = sdaLvl ? ST_IGNORE : ST_TX_NEXT;
        end
        ST_TX_NEXT: begin
          if (sclFall) begin
            stb.loadTx = 1'b1;
            bitCntN    = '0;
            stateN     = ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    driveLow = 1'b0;
    if ((state == ST_ACK_RISE || state == ST_ACK_END) && ackFlag) driveLow = 1'b1;
    if ((state == ST_TX || state == ST_TX_END) && !txMsb)          driveLow = 1'b1;
  end

endmodule

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int REG_IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tgtStrobeT            stb,
  input  logic                 sdaLvl,
  output logic [7:0]           rxByte,
  output logic                 txMsb,
  output logic                 wrValid,
  output logic [REG_IDX_W-1:0] wrAddr,
  output logic [7:0]           wrData
);

  localparam int REG_COUNT = 1 << REG_IDX_W;

  logic [7:0]                 rxShift;
  logic [7:0]                 txShift;
  logic [7:0]                 ptr;
  logic [REG_IDX_W-1:0]       idx;
  logic [REG_COUNT-1:0][7:0]  rdBus;

  assign idx    = ptr[REG_IDX_W-1:0];
  assign rxByte = rxShift;
  assign txMsb  = txShift[7];

  generate
    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                        q <= '0;
        else if (stb.writeReg && idx == REG_IDX_W'(i))    q <= rxShift;
      end
      assign rdBus[i] = q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      ptr     <= '0;
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrValid <= 1'b0;
      if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaLvl};
      if (stb.setPtr)  ptr     <= rxShift;
      if (stb.writeReg) begin
        wrValid <= 1'b1;
        wrAddr  <= idx;
        wrData  <= rxShift;
        ptr     <= ptr + 8'd1;
      end
      if (stb.loadTx) begin
        txShift <= rdBus[idx];
        ptr     <= ptr + 8'd1;
      end
      if (stb.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

endmodule

// File: rtl/i2c_tgt.sv
module i2c_tgt
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h60,
  parameter int         REG_IDX_W   = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic                 quietN,
  output logic                 sdaOe,
  output logic                 wrValid,
  output logic [REG_IDX_W-1:0] wrAddr,
  output logic [7:0]           wrData
);

  logic       sdaLvl;
  logic       sclRise;
  logic       sclFall;
  logic       startDet;
  logic       stopDet;
  logic [7:0] rxByte;
  logic       txMsb;
  logic       driveLow;
  tgtStrobeT  stb;

  i2c_tgt_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_tgt_ctrl #(.TGT_ADDR(TGT_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .txMsb(txMsb), .stb(stb), .driveLow(driveLow)
  );

  i2c_tgt_dp #(.REG_IDX_W(REG_IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .txMsb(txMsb), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  assign sdaOe = driveLow & quietN;

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic quietN,
  input logic sdaOe,
  input logic wrValid,
  input logic sclFall,
  input logic stopDet
);

  // R6
  sda_in_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && $stable(quietN)) |-> !sclIn);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  // R4
  wr_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> $past(sclFall));

endmodule

bind i2c_tgt i2c_tgt_chk i_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .quietN(quietN),
  .sdaOe(sdaOe), .wrValid(wrValid), .sclFall(sclFall), .stopDet(stopDet)
);

// File: tb/test_i2c_tgt.sv
`timescale 1ns/1ps
module test_i2c_tgt;

  localparam int Q  = 10;
  localparam int WD = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scl = 1'b1;
  logic       mSda = 1'b1;
  logic       quietN = 1'b1;
  logic       sdaOe;
  logic       sdaBus;
  logic       wrValid;
  logic [3:0] wrAddr;
  logic [7:0] wrData;

  int passCnt = 0;
  int totalCnt = 0;
  bit doneFlag = 0;

  int   logN = 0;
  logic [3:0] logAddr [64];
  logic [7:0] logData [64];
  int   oeInQuiet = 0;

  always #2 clk = ~clk;

  assign sdaBus = mSda & ~sdaOe;

  i2c_tgt i_i2c_tgt (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaBus), .quietN(quietN),
    .sdaOe(sdaOe), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData)
  );

  always @(posedge clk) begin
    if (wrValid && logN < 64) begin
      logAddr[logN] <= wrAddr;
      logData[logN] <= wrData;
      logN <= logN + 1;
    end
    if (!quietN && sdaOe) oeInQuiet <= oeInQuiet + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
  endtask

  task automatic waitQ;
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic busStart;
    mSda = 1'b1; waitQ; scl = 1'b1; waitQ; mSda = 1'b0; waitQ; scl = 1'b0; waitQ;
  endtask

  task automatic busStop;
    mSda = 1'b0; waitQ; scl = 1'b1; waitQ; mSda = 1'b1; waitQ;
  endtask

  task automatic putBit(input logic b);
    mSda = b; waitQ; scl = 1'b1; waitQ; waitQ; scl = 1'b0; waitQ;
  endtask

  task automatic getBit(output logic b);
    mSda = 1'b1; waitQ; scl = 1'b1; waitQ; b = sdaBus; waitQ; scl = 1'b0; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd);
    logic x;
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    getBit(x);
    ackd = !x;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      getBit(x);
      d[i] = x;
    end
    putBit(ackIt ? 1'b0 : 1'b1);
  endtask

  // start, write address, pointer byte
  task automatic setPointer(input logic [7:0] p, output logic a0, output logic a1);
    busStart;
    sendByte(8'hC0, a0);
    sendByte(p, a1);
  endtask

  task automatic testReset;
    chk(sdaOe == 1'b0, "R1 sdaOe after reset", sdaOe, 0);
    chk(wrValid == 1'b0, "R1 wrValid after reset", wrValid, 0);
  endtask

  task automatic testWriteOne;
    logic a0, a1, a2;
    int n0 = logN;
    setPointer(8'h03, a0, a1);
    sendByte(8'hA5, a2);
    busStop;
    chk(a0, "R2 address ack", a0, 1);
    chk(a1, "R4 pointer ack", a1, 1);
    chk(a2, "R4 data ack", a2, 1);
    chk(logN == n0 + 1, "R4 one store", logN - n0, 1);
    chk(logAddr[n0] == 4'd3 && logData[n0] == 8'hA5, "R4 store addr/data",
        {logAddr[n0], logData[n0]}, 12'h3A5);
  endtask

  task automatic testBurst;
    logic a0, a1, a2;
    logic [7:0] vals [3] = '{8'h11, 8'h22, 8'h33};
    int n0 = logN;
    setPointer(8'h05, a0, a1);
    for (int i = 0; i < 3; i++) sendByte(vals[i], a2);
    busStop;
    chk(logN == n0 + 3, "R5 burst store count", logN - n0, 3);
    for (int i = 0; i < 3; i++)
      chk(logAddr[n0+i] == 4'(5 + i) && logData[n0+i] == vals[i], "R5 burst increment",
          {logAddr[n0+i], logData[n0+i]}, {4'(5 + i), vals[i]});
  endtask

  task automatic testRead;
    logic a0, a1, a2;
    logic [7:0] d;
    logic [7:0] exp [3] = '{8'h11, 8'h22, 8'h33};
    setPointer(8'h05, a0, a1);
    busStart;
    sendByte(8'hC1, a2);
    chk(a2, "R2 read address ack", a2, 1);
    for (int i = 0; i < 3; i++) begin
      recvByte(i != 2, d);
      chk(d == exp[i], "R6 read data MSB first", d, exp[i]);
    end
    chk(sdaOe == 1'b0, "R7 release after nack", sdaOe, 0);
    busStop;
  endtask

  task automatic testWrap;
    logic a0, a1, a2;
    logic [7:0] d;
    int n0 = logN;
    setPointer(8'h0F, a0, a1);
    sendByte(8'h77, a2);
    sendByte(8'h88, a2);
    busStop;
    chk(logN == n0 + 2 && logAddr[n0] == 4'hF && logAddr[n0+1] == 4'h0, "R5 pointer wrap",
        {logAddr[n0], logAddr[n0+1]}, 8'hF0);
    setPointer(8'h0F, a0, a1);
    busStart;
    sendByte(8'hC1, a2);
    recvByte(1'b1, d);
    chk(d == 8'h77, "R5 read before wrap", d, 8'h77);
    recvByte(1'b0, d);
    chk(d == 8'h88, "R7 read after ack wraps", d, 8'h88);
    busStop;
  endtask

  task automatic testMismatch;
    logic a0, a1, a2;
    int n0 = logN;
    busStart;
    sendByte(8'hC2, a0);
    sendByte(8'h02, a1);
    sendByte(8'hEE, a2);
    chk(!a0, "R3 no ack wrong address", a0, 0);
    chk(!a1 && !a2, "R3 silent after mismatch", {a1, a2}, 0);
    busStop;
    chk(logN == n0, "R3 no store after mismatch", logN - n0, 0);
  endtask

  task automatic testStopMid;
    logic a0, a1, a2;
    logic [7:0] d;
    int n0 = logN;
    setPointer(8'h02, a0, a1);
    for (int i = 0; i < 4; i++) putBit(1'b1);
    busStop;
    chk(logN == n0, "R9 stop discards partial byte", logN - n0, 0);
    setPointer(8'h02, a0, a1);
    busStart;
    sendByte(8'hC1, a2);
    recvByte(1'b0, d);
    busStop;
    chk(d == 8'h00, "R9 register untouched by stop", d, 0);
  endtask

  task automatic testRestartMid;
    logic a0, a1, a2;
    logic [7:0] d;
    int n0 = logN;
    setPointer(8'h03, a0, a1);
    putBit(1'b0); putBit(1'b1); putBit(1'b1);
    busStart;
    sendByte(8'hC1, a2);
    chk(a2, "R9 address after mid-byte start", a2, 1);
    recvByte(1'b0, d);
    busStop;
    chk(d == 8'hA5, "R9 pointer kept across start", d, 8'hA5);
    chk(logN == n0, "R9 start discards partial byte", logN - n0, 0);
  endtask

  task automatic testQuiet;
    logic a0, a1, a2;
    logic [7:0] d;
    int n0 = logN;
    quietN = 1'b0;
    setPointer(8'h0A, a0, a1);
    sendByte(8'h5C, a2);
    busStop;
    chk(!a0 && !a1 && !a2, "R8 no ack while quiet", {a0, a1, a2}, 0);
    chk(logN == n0 + 1 && logData[n0] == 8'h5C, "R8 store while quiet", logData[n0], 8'h5C);
    setPointer(8'h0A, a0, a1);
    busStart;
    sendByte(8'hC1, a2);
    recvByte(1'b0, d);
    busStop;
    chk(d == 8'hFF, "R8 no read data while quiet", d, 8'hFF);
    chk(oeInQuiet == 0, "R8 sdaOe held off", oeInQuiet, 0);
    quietN = 1'b1;
    waitQ;
    setPointer(8'h0A, a0, a1);
    busStart;
    sendByte(8'hC1, a2);
    recvByte(1'b0, d);
    busStop;
    chk(d == 8'h5C, "R8 value stored under quiet", d, 8'h5C);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    testReset;
    rstN = 1'b1;
    waitQ;
    testReset;
    testWriteOne;
    testBurst;
    testRead;
    testWrap;
    testMismatch;
    testStopMid;
    testRestartMid;
    testQuiet;
    doneFlag = 1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!doneFlag) begin
      totalCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

endmodule